// File: doc/BRIEF.md
# Serial MII Transmit Serializer (MAC side)

This block drives the transmit half of a serial MII link from the MAC end. It counts out fixed 10-bit segments on one serial line and raises a one-clock sync pulse on the first bit of every segment. Each segment carries an error flag, a transmit-enable flag and one data byte. At 100 Mbps every segment carries a fresh byte. At 10 Mbps each segment is sent ten times in a row before the next one is loaded.

Bytes enter through a valid/ready stream. `in_ready` is high for exactly one clock: the last bit-clock of a segment group, which is the clock before the next group's sync pulse. A byte transfers when `in_valid` and `in_ready` are both high at a rising edge. Back-pressure rules: the source may raise `in_valid` at any time. While `in_valid` is high and no transfer has occurred, the source must hold `in_valid`, `in_data` and `in_err` steady. If `in_valid` is low at the load point, the block sends an idle group. The speed input is a plain level and is sampled only at load points.

Top module: `smii_tx_serializer`

## Requirements
- R1: `sync_out` is high for one clock at bit 0 of every segment, once every 10 clocks. It is high in the first clock after reset is released and is also high while reset is held.
- R2: An accepted byte is sent as a segment with bit 0 = `in_err`, bit 1 = 1 (transmit enable) and bits 2..9 = `in_data[0]`..`in_data[7]`, least significant bit first. Segment bit k is on `tx_out` k clocks after the sync clock.
- R3: In fast mode (`slow_mode` sampled as 0), each accepted byte is sent in exactly one segment. With `in_valid` held high, a new byte is taken every segment and bytes leave in the order they were accepted.
- R4: In slow mode (`slow_mode` sampled as 1), each loaded segment is sent in ten consecutive segments, and the next byte is taken only after the tenth one.
- R5: `in_ready` is high only in bit-clock 9 of the final segment of a group, and it is then always high, whether or not `in_valid` is high. The segment that follows is either the accepted byte or an idle segment.
- R6: When `in_valid` is low at a load point, the next group consists of idle segments with all ten bits 0.
- R7: `slow_mode` is sampled only at load points. A change in the middle of a group neither shortens nor lengthens that group. After reset the block is in fast mode.
- R8: While reset is held, `in_ready` and `tx_out` are 0. After release, `tx_out` stays 0 for the first segment, and the first `in_ready` comes in clock 9 after release.
- R9: The error flag travels independently of the data. Bit 0 of a segment equals the `in_err` value that was accepted with its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1 selects 10 Mbps (ten repeats), 0 selects 100 Mbps |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| in_data | input | 8 | Byte to transmit |
| in_err | input | 1 | Transmit error flag sent with the byte |
| sync_out | output | 1 | Segment sync pulse |
| tx_out | output | 1 | Serial transmit line |

## Verification
The serial line is fed into a reference decoder. The byte order, error flags and repeat count it recovers are compared with the bytes the bench handed over. Fast mode is run both back-to-back, which separates one-segment-per-byte from any skipping or doubling, and with random gaps, which exercises idle segments and the held-offer rule. Slow mode is run with full and sparse traffic to show that every byte appears exactly ten times. A phase that flips `slow_mode` at random points mid-group shows whether the mode is latched only at group boundaries, because any early latching changes the ready timing and the repeat counts.

// File: rtl/smii_ser_pkg.sv
package smii_ser_pkg;
  localparam int BYTE_W = 8;
  localparam int SEG_W  = BYTE_W + 2;

  typedef logic [SEG_W-1:0] seg_t;

  typedef enum logic {
    SPD_FAST = 1'b0,
    SPD_SLOW = 1'b1
  } speed_e;

  function automatic seg_t pack_seg(input logic [BYTE_W-1:0] data, input logic err);
    return {data, 1'b1, err};
  endfunction
endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer
  import smii_ser_pkg::*;
#(
  parameter int SEG_BITS = SEG_W,
  parameter int REPEAT   = 10,
  localparam int BIT_W   = $clog2(SEG_BITS),
  localparam int REP_W   = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_req,
  output logic [BIT_W-1:0] bit_idx,
  output logic             group_end,
  output logic             sync
);
  logic [REP_W-1:0] rep_q;
  speed_e           spd_q;
  logic             last_bit;

  assign last_bit  = (bit_idx == BIT_W'(SEG_BITS - 1));
  assign group_end = last_bit && ((spd_q == SPD_FAST) || (rep_q == REP_W'(REPEAT - 1)));
  assign sync      = (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      rep_q   <= '0;
      spd_q   <= SPD_FAST;
    end else if (group_end) begin
      bit_idx <= '0;
      rep_q   <= '0;
      spd_q   <= slow_req ? SPD_SLOW : SPD_FAST;
    end else if (last_bit) begin
      bit_idx <= '0;
      rep_q   <= rep_q + 1'b1;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R4: repeat counter never passes its last value
  a_r4_rep_range: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= REP_W'(REPEAT - 1));
  // R7: the speed is only taken over at a group boundary
  a_r7_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !group_end |=> $stable(spd_q));
  // R3: fast mode keeps the repeat counter at zero
  a_r3_fast_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (group_end && !slow_req) |=> (rep_q == '0) && (spd_q == SPD_FAST));
endmodule

// File: rtl/smii_seg_loader.sv
module smii_seg_loader
  import smii_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_err,
  output logic              in_ready,
  output seg_t              seg_q
);
  assign in_ready = load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
    end else if (load) begin
      seg_q <= in_valid ? pack_seg(in_data, in_err) : '0;
    end
  end

  // R6: an empty load point produces an all-zero segment
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !in_valid) |=> (seg_q == '0));
  // R2: an accepted byte lands with enable set and data intact
  a_r2_byte_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid) |=> seg_q[1] && (seg_q[SEG_W-1:2] == $past(in_data)));
  // R9: error flag follows its byte
  a_r9_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_valid) |=> (seg_q[0] == $past(in_err)));
  // R4: the segment is held for the whole group
  a_r4_seg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_q));
endmodule

// File: rtl/smii_bit_mux.sv
module smii_bit_mux #(
  parameter int SEG_BITS = 10,
  localparam int BIT_W   = $clog2(SEG_BITS)
) (
  input  logic [SEG_BITS-1:0] seg,
  input  logic [BIT_W-1:0]    bit_idx,
  output logic                line
);
  logic [SEG_BITS-1:0] hit;

  for (genvar i = 0; i < SEG_BITS; i++) begin : g_pick
    assign hit[i] = seg[i] && (bit_idx == BIT_W'(i));
  end

  assign line = |hit;
endmodule

// File: rtl/smii_tx_serializer.sv
module smii_tx_serializer
  import smii_ser_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_err,
  output logic              sync_out,
  output logic              tx_out
);
  localparam int BIT_W = $clog2(SEG_W);

  logic [BIT_W-1:0] bit_idx;
  logic             group_end;
  seg_t             seg_q;

  smii_seg_timer #(.SEG_BITS(SEG_W), .REPEAT(REPEAT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_req  (slow_mode),
    .bit_idx   (bit_idx),
    .group_end (group_end),
    .sync      (sync_out)
  );

  smii_seg_loader u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (group_end),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_err   (in_err),
    .in_ready (in_ready),
    .seg_q    (seg_q)
  );

  smii_bit_mux #(.SEG_BITS(SEG_W)) u_mux (
    .seg     (seg_q),
    .bit_idx (bit_idx),
    .line    (tx_out)
  );

  // R1: sync lasts a single clock
  a_r1_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);
  // R5: ready is always followed by the next sync
  a_r5_ready_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> sync_out);
  // R5: ready never coincides with a sync clock
  a_r5_ready_not_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && sync_out));
endmodule

// File: tb/smii_tx_serializer_test.sv
`timescale 1ns/1ps
module smii_tx_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_err = 1'b0;
  logic       in_ready, sync_out, tx_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [9:0] aq[$];   // {mode, data, err} expected per segment
  logic [9:0] dq[$];   // decoded enabled segments

  // bench model state
  int         mb = 0, mr = 0, t = 0;
  bit         mm = 0;
  logic [9:0] seg_m = '0;
  bit         last_taken = 0;

  always #10 clk = ~clk;

  smii_tx_serializer uut (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_err(in_err),
    .sync_out(sync_out), .tx_out(tx_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  function automatic logic [9:0] exp_seg(input logic [7:0] d, input logic e);
    return {d, 1'b1, e};
  endfunction

  // reference decoder
  int         dcnt = 0;
  logic [9:0] dsh = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      dcnt = 0;
    end else begin
      if (sync_out) begin
        dsh = '0;
        dsh[0] = tx_out;
        dcnt = 1;
      end else if (dcnt > 0) begin
        dsh[dcnt] = tx_out;
        dcnt++;
      end
      if (dcnt == 10) begin
        if (dsh[1]) dq.push_back(dsh);
        dcnt = 0;
      end
    end
  end

  task automatic step(input int pv, input int mc);
    bit exp_sync, exp_rdy, exp_tx, hold;
    string tg;
    exp_sync = (mb == 0);
    exp_rdy  = (mb == 9) && (!mm || mr == 9);
    check(sync_out == exp_sync, "R1 sync", sync_out, exp_sync);
    check(in_ready == exp_rdy, (mc == 2) ? "R7 ready" : "R5 ready", in_ready, exp_rdy);
    exp_tx = seg_m[mb];
    tg = (t < 10) ? "R8 tx" : (seg_m[1] ? "R2 tx" : "R6 tx");
    check(tx_out == exp_tx, tg, tx_out, exp_tx);
    hold = in_valid && !last_taken;
    if (!hold) begin
      in_valid = ($urandom % 100) < pv;
      in_data  = 8'($urandom);
      in_err   = ($urandom % 8) == 0;
    end
    if (mc == 0) slow_mode = 1'b0;
    else if (mc == 1) slow_mode = 1'b1;
    else if (mc == 2 && ($urandom % 37) == 0) slow_mode = !slow_mode;
    last_taken = exp_rdy && in_valid;
    if (exp_rdy) begin
      seg_m = in_valid ? exp_seg(in_data, in_err) : '0;
      if (in_valid)
        repeat (slow_mode ? 10 : 1) aq.push_back({slow_mode, in_data, in_err});
      mm = slow_mode; mb = 0; mr = 0;
    end else if (mb == 9) begin
      mb = 0; mr++;
    end else begin
      mb++;
    end
    t++;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // reset state, R8 and R1
    check(in_ready == 1'b0, "R8 reset ready", in_ready, 0);
    check(tx_out == 1'b0, "R8 reset tx", tx_out, 0);
    check(sync_out == 1'b1, "R1 reset sync", sync_out, 1);
    rst_n = 1'b1;
    // idle start, then directed back-to-back fast traffic (R3)
    repeat (30)   step(0, 0);
    repeat (400)  step(100, 0);
    repeat (2000) step(50, 0);
    // slow mode, full and sparse (R4)
    repeat (3000) step(100, 1);
    repeat (4000) step(40, 1);
    // mode flips mid-group (R7)
    repeat (8000) step(70, 2);
    // fast idle (R6), then drain
    repeat (300)  step(0, 0);
    check(dq.size() == aq.size(), "R3/R4 segment count", dq.size(), aq.size());
    for (int i = 0; i < dq.size() && i < aq.size(); i++) begin
      check(dq[i][9:2] == aq[i][8:1], aq[i][9] ? "R4 data order" : "R3 data order",
            dq[i][9:2], aq[i][8:1]);
      check(dq[i][0] == aq[i][0], "R9 err flag", dq[i][0], aq[i][0]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule